// File: doc/BRIEF.md
# Double-Precision Compare-to-Mask Unit

This block compares two IEEE-754 binary64 operands, A and B, and returns the outcome as a 128-bit doubleword mask instead of condition bits. A 2-bit select picks one of four relations: equal, A greater than B, A greater than or equal to B, or not equal. When the relation holds, the upper doubleword of the result is all ones and the lower doubleword is zero. When the relation does not hold, all 128 bits are zero. The mask is meant to be written into a 128-bit vector register and used directly as a lane mask by later select or logic operations.

Alongside the mask, the unit classifies both operands. It raises two invalid-operation pulses: one for a signaling NaN operand, and one for an invalid compare. The invalid-compare pulse applies only to the ordered relations (greater-than and greater-or-equal). An invalid-operation trap-enable input decides whether an invalid case still updates the destination. If the trap enable is set and either pulse fires, the write-enable is withheld. The flags are single-cycle pulses, and a surrounding status register is expected to accumulate them into sticky bits.

The datapath is one registered stage. A request presented with `in_valid` produces its mask, write-enable and flags on the next clock edge, qualified by `out_valid`. There is no control state machine. The only state is the output register, which is cleared by reset.

Top module: `dpcmp_mask_unit`

## Requirements
- R1: `op_sel` encodes 0 = equal, 1 = A greater than B, 2 = A greater than or equal to B, 3 = not equal. A true relation gives `result[127:64]` all ones and `result[63:0]` zero. A false relation gives all 128 bits zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result_we`, `flag_snan` and `flag_vc` are low whenever `out_valid` is low.
- R3: Non-NaN operands are ordered by sign, then by magnitude. The magnitude order is reversed when both operands are negative, and infinities are the largest magnitudes.
- R4: +0 and -0 compare equal in every relation.
- R5: A NaN is exponent all ones (bits 62:52) with a nonzero fraction. If either operand is a NaN, the pair is unordered: equal, greater-than and greater-or-equal are false, and not-equal is true.
- R6: `flag_snan` pulses with the result for every relation when either operand is a signaling NaN, which means fraction bit 51 is 0.
- R7: For greater-than and greater-or-equal with no signaling NaN present, `flag_vc` pulses when either operand is a quiet NaN (fraction bit 51 is 1).
- R8: For greater-than and greater-or-equal with a signaling NaN present, `flag_vc` pulses only if `trap_en` is 0, even when the other operand is a quiet NaN.
- R9: Equal and not-equal never raise `flag_vc`.
- R10: A valid result has `result_we` low when `trap_en` was 1 and either flag fires, and high in every other case.
- R11: During and right after reset, `out_valid`, `result_we` and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| op_sel | input | 2 | Relation select (R1 encoding) |
| opnd_a | input | 64 | Operand A, binary64 |
| opnd_b | input | 64 | Operand B, binary64 |
| trap_en | input | 1 | Invalid-operation trap enable |
| out_valid | output | 1 | Result valid, one cycle after request |
| result | output | 128 | Doubleword mask |
| result_we | output | 1 | Destination write enable |
| flag_snan | output | 1 | Signaling-NaN invalid pulse |
| flag_vc | output | 1 | Invalid-compare pulse |

## Verification
The four relations are each driven with operand pairs chosen to separate the decision paths:
- Less, greater and equal positives show that greater-than and greater-or-equal differ only on equality.
- Two negatives catch a magnitude order that was not reversed.
- Mixed signs and infinities check the sign path.
- A denormal against zero checks that nonzero denormals are not treated as zero.
- Opposite-signed zeros check the signed-zero merge.

NaN pairs cover each NaN kind on either side, and a signaling and a quiet NaN together, all under both trap-enable settings. This separates the signaling-NaN flag from the invalid-compare flag and shows the write suppression.

Idle cycles between requests check that the valid and pulse outputs appear only with a request.

// File: rtl/dpcmp_pkg.sv
package dpcmp_pkg;

    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;

    typedef enum logic [1:0] {
        OP_EQ = 2'd0,
        OP_GT = 2'd1,
        OP_GE = 2'd2,
        OP_NE = 2'd3
    } cmp_op_e;

    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_inf;
        logic is_nan;
        logic is_snan;
        logic is_qnan;
    } fp_class_t;

endpackage

// File: rtl/dpcmp_classify.sv
module dpcmp_classify
    import dpcmp_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW:0] opnd,
    output fp_class_t      cls
);
    localparam int SIGN_BIT = EW + FW;

    logic [EW-1:0] exp_f;
    logic [FW-1:0] frac_f;
    logic          exp_max;
    logic          frac_nz;

    always_comb begin
        exp_f       = opnd[SIGN_BIT-1:FW];
        frac_f      = opnd[FW-1:0];
        exp_max     = &exp_f;
        frac_nz     = |frac_f;
        cls.sign    = opnd[SIGN_BIT];
        cls.is_zero = (exp_f == '0) && !frac_nz;
        cls.is_inf  = exp_max && !frac_nz;
        cls.is_nan  = exp_max && frac_nz;
        cls.is_qnan = cls.is_nan && frac_f[FW-1];
        cls.is_snan = cls.is_nan && !frac_f[FW-1];
    end

    // R5: a NaN is exactly one of quiet or signaling, never also zero or infinite
    always_comb begin
        a_r5_class_exclusive: assert (!(cls.is_snan && cls.is_qnan)
                                      && !(cls.is_nan && (cls.is_zero || cls.is_inf)))
            else $error("a_r5_class_exclusive");
    end

endmodule

// File: rtl/dpcmp_order.sv
module dpcmp_order
    import dpcmp_pkg::*;
#(
    parameter int W = FP_W
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  fp_class_t    cls_a,
    input  fp_class_t    cls_b,
    output logic         unordered,
    output logic         a_eq_b,
    output logic         a_gt_b
);
    localparam int MAG_W = W - 1;

    logic [MAG_W-1:0] mag_a;
    logic [MAG_W-1:0] mag_b;
    logic             mag_eq;
    logic             mag_a_gt;
    logic             both_zero;
    logic             gt_raw;

    always_comb begin
        mag_a     = opnd_a[MAG_W-1:0];
        mag_b     = opnd_b[MAG_W-1:0];
        mag_eq    = (mag_a == mag_b);
        mag_a_gt  = (mag_a > mag_b);
        both_zero = cls_a.is_zero && cls_b.is_zero;
        unordered = cls_a.is_nan || cls_b.is_nan;

        unique case ({cls_a.sign, cls_b.sign})
            2'b00:   gt_raw = mag_a_gt;
            2'b11:   gt_raw = !mag_a_gt && !mag_eq;
            2'b01:   gt_raw = 1'b1;
            default: gt_raw = 1'b0;
        endcase

        a_eq_b = !unordered && (both_zero || (mag_eq && (cls_a.sign == cls_b.sign)));
        a_gt_b = !unordered && !both_zero && gt_raw;
    end

    // R3: ordered outcomes are mutually exclusive
    always_comb begin
        a_r3_eq_gt_exclusive: assert (!(a_eq_b && a_gt_b))
            else $error("a_r3_eq_gt_exclusive");
    end

endmodule

// File: rtl/dpcmp_excpt.sv
module dpcmp_excpt
    import dpcmp_pkg::*;
(
    input  cmp_op_e   op,
    input  fp_class_t cls_a,
    input  fp_class_t cls_b,
    input  logic      trap_en,
    output logic      snan_hit,
    output logic      vc_hit,
    output logic      write_ok
);
    logic ordered_op;
    logic any_qnan;

    always_comb begin
        unique case (op)
            OP_GT, OP_GE: ordered_op = 1'b1;
            default:      ordered_op = 1'b0;
        endcase
        snan_hit = cls_a.is_snan || cls_b.is_snan;
        any_qnan = cls_a.is_qnan || cls_b.is_qnan;
        if (!ordered_op)
            vc_hit = 1'b0;
        else if (snan_hit)
            vc_hit = !trap_en;
        else
            vc_hit = any_qnan;
        write_ok = !(trap_en && (snan_hit || vc_hit));
    end

endmodule

// File: rtl/dpcmp_mask_unit.sv
module dpcmp_mask_unit
    import dpcmp_pkg::*;
#(
    parameter int W = FP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [1:0]     op_sel,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    input  logic           trap_en,
    output logic           out_valid,
    output logic [2*W-1:0] result,
    output logic           result_we,
    output logic           flag_snan,
    output logic           flag_vc
);
    localparam int MASK_W = 2 * W;

    cmp_op_e   op;
    fp_class_t cls_a;
    fp_class_t cls_b;
    logic      unordered;
    logic      a_eq_b;
    logic      a_gt_b;
    logic      snan_hit;
    logic      vc_hit;
    logic      write_ok;
    logic      hit;

    logic              valid_d;
    logic [MASK_W-1:0] mask_d;
    logic              we_d;
    logic              snan_d;
    logic              vc_d;

    assign op = cmp_op_e'(op_sel);

    dpcmp_classify #(.EW(EXP_W), .FW(W - 1 - EXP_W)) u_cls_a (.opnd(opnd_a), .cls(cls_a));
    dpcmp_classify #(.EW(EXP_W), .FW(W - 1 - EXP_W)) u_cls_b (.opnd(opnd_b), .cls(cls_b));

    dpcmp_order #(.W(W)) u_order (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .cls_a     (cls_a),
        .cls_b     (cls_b),
        .unordered (unordered),
        .a_eq_b    (a_eq_b),
        .a_gt_b    (a_gt_b)
    );

    dpcmp_excpt u_excpt (
        .op       (op),
        .cls_a    (cls_a),
        .cls_b    (cls_b),
        .trap_en  (trap_en),
        .snan_hit (snan_hit),
        .vc_hit   (vc_hit),
        .write_ok (write_ok)
    );

    // next-value logic
    always_comb begin
        unique case (op)
            OP_EQ: hit = a_eq_b;
            OP_GT: hit = a_gt_b;
            OP_GE: hit = a_gt_b || a_eq_b;
            OP_NE: hit = !a_eq_b;
        endcase
        valid_d = in_valid;
        mask_d  = hit ? {{W{1'b1}}, {W{1'b0}}} : '0;
        we_d    = in_valid && write_ok;
        snan_d  = in_valid && snan_hit;
        vc_d    = in_valid && vc_hit;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            result_we <= 1'b0;
            flag_snan <= 1'b0;
            flag_vc   <= 1'b0;
        end else begin
            out_valid <= valid_d;
            result    <= mask_d;
            result_we <= we_d;
            flag_snan <= snan_d;
            flag_vc   <= vc_d;
        end
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(result_we || flag_snan || flag_vc));

    a_r1_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        result[W-1:0] == '0 && (result[MASK_W-1:W] == '0 || &result[MASK_W-1:W]));

    a_r9_no_vc_eq_ne: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel == 2'd0 || op_sel == 2'd3)) |=> !flag_vc);

    a_r10_suppress_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !result_we) |-> (flag_snan || flag_vc));

    a_r8_trap_blocks_vc_on_snan: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && trap_en) |=> !(flag_snan && flag_vc));

endmodule

// File: tb/dpcmp_mask_unit_tb.sv
module dpcmp_mask_unit_tb;

    localparam logic [63:0] PZ    = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZ    = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO   = 64'h4000_0000_0000_0000;
    localparam logic [63:0] MONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] MTWO  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] DEN   = 64'h0000_0000_0000_0001;
    localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] NSNAN = 64'hFFF4_0000_0000_0000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [1:0]   op_sel;
    logic [63:0]  opnd_a;
    logic [63:0]  opnd_b;
    logic         trap_en;
    logic         out_valid;
    logic [127:0] result;
    logic         result_we;
    logic         flag_snan;
    logic         flag_vc;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic  vld;
        logic  we;
        logic  sn;
        logic  vc;
        logic  hit;
        string tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    dpcmp_mask_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .trap_en   (trap_en),
        .out_valid (out_valid),
        .result    (result),
        .result_we (result_we),
        .flag_snan (flag_snan),
        .flag_vc   (flag_vc)
    );

    function automatic logic is_nan(input logic [63:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // expected model, built from the requirements
    function automatic exp_t model(input logic [1:0] op, input logic [63:0] a,
                                   input logic [63:0] b, input logic te, input string tag);
        exp_t e;
        logic any_nan, any_s, any_q, ord;
        real ra, rb;
        any_nan = is_nan(a) || is_nan(b);
        any_s   = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
        any_q   = (is_nan(a) && a[51]) || (is_nan(b) && b[51]);
        ord     = (op == 2'd1) || (op == 2'd2);
        e.vld = 1'b1;
        e.sn  = any_s;
        e.vc  = ord && (any_s ? !te : any_q);
        e.we  = !(te && (e.sn || e.vc));
        if (any_nan) begin
            e.hit = (op == 2'd3);
        end else begin
            ra = $bitstoreal(a);
            rb = $bitstoreal(b);
            case (op)
                2'd0:    e.hit = (ra == rb);
                2'd1:    e.hit = (ra > rb);
                2'd2:    e.hit = (ra >= rb);
                default: e.hit = (ra != rb);
            endcase
        end
        e.tag = tag;
        return e;
    endfunction

    task automatic send(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                        input logic te, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        op_sel   = op;
        opnd_a   = a;
        opnd_b   = b;
        trap_en  = te;
        q.push_back(model(op, a, b, te, tag));
    endtask

    task automatic idle();
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0;
        op_sel   = 2'd1;
        opnd_a   = SNAN;
        opnd_b   = QNAN;
        trap_en  = 1'b0;
        e.vld = 1'b0; e.we = 1'b0; e.sn = 1'b0; e.vc = 1'b0; e.hit = 1'b0;
        e.tag = "R2 idle";
        q.push_back(e);
    endtask

    // monitor: each item is checked one cycle after it was driven
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " R2 valid"}, {127'd0, out_valid}, {127'd0, e.vld});
                chk({e.tag, " R10 we"}, {127'd0, result_we}, {127'd0, e.we});
                chk({e.tag, " R6 snan"}, {127'd0, flag_snan}, {127'd0, e.sn});
                chk({e.tag, " R7 R8 R9 vc"}, {127'd0, flag_vc}, {127'd0, e.vc});
                if (e.we)
                    chk({e.tag, " R1 mask"}, result,
                        e.hit ? {{64{1'b1}}, 64'd0} : 128'd0);
            end
        end
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] pa[11];
        logic [63:0] pb[11];
        string       pt[11];
        logic [63:0] na[6];
        logic [63:0] nb[6];
        rst_n = 1'b0; in_valid = 1'b1; op_sel = 2'd0;
        opnd_a = ONE; opnd_b = ONE; trap_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset outputs", {124'd0, out_valid, result_we, flag_snan, flag_vc}, 128'd0);
        @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0;
        #1;
        chk("R11 after reset", {124'd0, out_valid, result_we, flag_snan, flag_vc}, 128'd0);

        pa = '{ONE, TWO, ONE, MONE, MTWO, PZ, NZ, PINF, NINF, DEN, MONE};
        pb = '{TWO, ONE, ONE, MTWO, MONE, NZ, PZ, TWO, MTWO, PZ, ONE};
        pt = '{"R3 pos less", "R3 pos greater", "R1 equal", "R3 neg reversed",
               "R3 neg reversed2", "R4 +0 vs -0", "R4 -0 vs +0", "R3 +inf",
               "R3 -inf", "R3 denormal", "R3 mixed sign"};
        for (int op = 0; op < 4; op++) begin
            for (int i = 0; i < 11; i++) begin
                send(2'(op), pa[i], pb[i], 1'(i % 2), pt[i]);
            end
            idle();
        end

        na = '{QNAN, ONE, SNAN, ONE, SNAN, QNAN};
        nb = '{ONE, QNAN, ONE, NSNAN, QNAN, NSNAN};
        for (int te = 0; te < 2; te++) begin
            for (int op = 0; op < 4; op++) begin
                for (int i = 0; i < 6; i++) begin
                    send(2'(op), na[i], nb[i], 1'(te), "R5 R6 R7 R8 NaN pair");
                end
                idle();
                idle();
            end
        end
        idle();
        idle();
        wait (q.size() == 0);
        @(posedge clk);
        #2;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule